// File: doc/BRIEF.md
# Serial Word Transmitter with In-Band Parity Slot

This block takes a small parallel word, records it together with its parity, and sends it out on one serial data line with a strobe line beside it. It is meant for a receiver that shifts the data line in on each strobe. A frame has one slot per data bit, sent most significant bit first, and then one more slot for the parity bit. A selector moves the data line from the shift path to the stored parity value in that last slot, so no separate parity wire is needed.

The pacing comes from the `tick_i` input. Each accepted tick raises the strobe for one system clock. The data line is settled before the strobe rises and holds until the strobe falls. The slot advances in the clock after the strobe. When the last strobe ends, the block goes idle, raises a one-cycle done pulse and accepts the next word.

Top module: `par_serial_tx`

## Requirements
- R1: A low `rst_n` at a clock edge clears the block. From the next cycle on, `ser_o`, `strobe_o`, `busy_o` and `done_o` are all 0.
- R2: When `start_i` is high at an edge while `busy_o` is low, the block captures `word_i` and `busy_o` is 1 from the next cycle.
- R3: The first four strobes of a frame present the data bits in the order word[3], word[2], word[1], word[0].
- R4: The fifth strobe presents the parity bit, which is the XOR of the four data bits, so it is 1 when the word holds an odd count of ones.
- R5: Data and parity are fixed at capture. Changes on `word_i` during a frame do not alter the bits that are sent.
- R6: A tick seen while busy, with no strobe pending, gives `strobe_o` high for exactly one cycle. `ser_o` holds the same value in the cycle before the strobe rises and while the strobe is high. Ticks that arrive while the strobe is high are ignored.
- R7: A `start_i` seen while `busy_o` is high is ignored. The frame in progress goes on unchanged.
- R8: A frame has exactly five strobes. In the cycle after the fifth strobe, `busy_o` is 0 and `done_o` is 1, for one cycle only.
- R9: While idle, `ser_o` is 0 and ticks give no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low clear |
| start_i | input | 1 | Request to capture and send `word_i` |
| word_i | input | 4 | Parallel word to send |
| tick_i | input | 1 | Slot pacing tick |
| ser_o | output | 1 | Serial data line |
| strobe_o | output | 1 | One-cycle strobe per slot |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse when a frame ends |

## Verification
The hardest case to reach from the ports is a request that lands in the exact cycle the done pulse appears. In that cycle the block has just gone idle, so the request must start a new frame at once, with no lost slot. The stimulus therefore raises `start_i` as soon as it sees done, and also runs frames with a tick on every clock, so that ticks arrive while a strobe is still high. A reference model in the bench, built on a queue of pending bits, predicts all four outputs on every cycle. Separate checks compare each whole captured frame with the word that was accepted.

// File: rtl/par_tx_pkg.sv
// Package: shared defaults and helpers for the parity serial transmitter.
// Assumes nothing beyond the width being at least two bits.
package par_tx_pkg;
    localparam int DEF_DATA_W = 4;

    // Reduction parity of a word of any width up to 32 bits.
    function automatic logic odd_ones(input logic [31:0] v, input int w);
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < w; i++) acc = acc ^ v[i];
        return acc;
    endfunction
endpackage

// File: rtl/par_tx_shifter.sv
// Shift path: captures the word and its parity on load, and shifts out MSB first.
// Assumes load and shift are never high in the same cycle.
module par_tx_shifter #(
    parameter int DATA_W = par_tx_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              shift_en,
    input  logic [DATA_W-1:0] word_i,
    output logic              msb_o,
    output logic              par_o
);
    logic [DATA_W-1:0] sh_q;
    logic              par_q;

    // Hold the word being sent, and its parity, which is fixed at load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            par_q <= 1'b0;
        end else if (load_en) begin
            sh_q  <= word_i;
            par_q <= par_tx_pkg::odd_ones(32'(word_i), DATA_W);
        end else if (shift_en) begin
            sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
        end
    end

    assign msb_o = sh_q[DATA_W-1];
    assign par_o = par_q;
endmodule

// File: rtl/par_tx_sequencer.sv
// Sequencer: tracks the slot count, raises one strobe per tick, and produces busy and done.
// Assumes ticks may come on any cycle; extra ticks are dropped while a strobe is pending.
module par_tx_sequencer #(
    parameter int DATA_W = par_tx_pkg::DEF_DATA_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic tick_i,
    output logic load_en,
    output logic shift_en,
    output logic last_slot,
    output logic strobe_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

    logic [CNT_W-1:0] slot_q;
    logic             busy_q, pend_q, done_q;

    assign load_en   = !busy_q && start_i;
    assign last_slot = (slot_q == LAST);
    assign shift_en  = busy_q && pend_q && !last_slot;

    // Slot progression: strobe on a tick, advance after the strobe, finish after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            busy_q <= 1'b0;
            pend_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start_i) begin
                    busy_q <= 1'b1;
                    slot_q <= '0;
                    pend_q <= 1'b0;
                end
            end else if (pend_q) begin
                pend_q <= 1'b0;
                if (last_slot) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    slot_q <= slot_q + 1'b1;
                end
            end else if (tick_i) begin
                pend_q <= 1'b1;
            end
        end
    end

    assign strobe_o = pend_q;
    assign busy_o   = busy_q;
    assign done_o   = done_q;
endmodule

// File: rtl/par_serial_tx.sv
// Top: serial transmitter that sends the data bits and then an in-band parity slot.
// Assumes rst_n is applied before the first word; the output selector uses the terminal slot.
module par_serial_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [3:0] word_i,
    input  logic       tick_i,
    output logic       ser_o,
    output logic       strobe_o,
    output logic       busy_o,
    output logic       done_o
);
    localparam int DATA_W = 4;

    logic load_en, shift_en, last_slot, msb, par;

    par_tx_sequencer #(.DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick_i),
        .load_en(load_en), .shift_en(shift_en), .last_slot(last_slot),
        .strobe_o(strobe_o), .busy_o(busy_o), .done_o(done_o)
    );

    par_tx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .shift_en(shift_en),
        .word_i(word_i), .msb_o(msb), .par_o(par)
    );

    // Output selector: shifted data in the data slots, stored parity in the last slot, 0 when idle.
    always_comb begin
        if (!busy_o)        ser_o = 1'b0;
        else if (last_slot) ser_o = par;
        else                ser_o = msb;
    end
endmodule

// File: rtl/par_serial_tx_chk.sv
// Checker: port-level timing properties of the transmitter, attached by bind.
module par_serial_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic tick_i,
    input logic ser_o,
    input logic strobe_o,
    input logic busy_o,
    input logic done_o
);
    AST_CLEAR_STATE: assert property (@(posedge clk) !rst_n |=> (!busy_o && !strobe_o && !done_o && !ser_o)); // R1
    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n) (!busy_o && start_i) |=> busy_o); // R2
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) strobe_o |=> !strobe_o); // R6
    AST_SER_SETTLED: assert property (@(posedge clk) disable iff (!rst_n) (busy_o && !strobe_o) |=> (!strobe_o || $stable(ser_o))); // R6
    AST_TICK_STROBES: assert property (@(posedge clk) disable iff (!rst_n) (busy_o && !strobe_o && tick_i) |=> strobe_o); // R6
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (!busy_o && $past(strobe_o))); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy_o |-> (!strobe_o && !ser_o)); // R9
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (busy_o && !strobe_o) |=> busy_o); // R7
endmodule

bind par_serial_tx par_serial_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick_i),
    .ser_o(ser_o), .strobe_o(strobe_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/par_serial_tx_tb.sv
module par_serial_tx_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0, start_i = 1'b0, tick_i = 1'b0;
    logic [3:0] word_i = 4'h0;
    logic ser_o, strobe_o, busy_o, done_o;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #5 clk = ~clk;

    par_serial_tx u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_i(word_i), .tick_i(tick_i),
        .ser_o(ser_o), .strobe_o(strobe_o), .busy_o(busy_o), .done_o(done_o)
    );

    // Reference model: a queue of pending bits, consumed one per strobe.
    bit m_busy = 0, m_pend = 0, m_done = 0;
    bit q[$];
    bit [4:0] exp_frame, got_frame;
    int got_n = 0;
    bit prev_ser = 0, prev_strobe = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_pend = 0; m_done = 0; q.delete();
        end else begin
            m_done = 0;
            if (!m_busy) begin
                if (start_i) begin
                    q = '{word_i[3], word_i[2], word_i[1], word_i[0],
                          word_i[0] ^ word_i[1] ^ word_i[2] ^ word_i[3]};
                    exp_frame = {word_i, ^word_i};
                    m_busy = 1; m_pend = 0;
                end
            end else if (m_pend) begin
                m_pend = 0;
                void'(q.pop_front());
                if (q.size() == 0) begin m_busy = 0; m_done = 1; end
            end else if (tick_i) begin
                m_pend = 1;
            end
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Every-cycle comparison, plus frame capture and strobe-edge stability.
    always @(negedge clk) begin
        if (cyc > 0) begin
            check("R1/R2/R7/R8 busy", busy_o, m_busy);
            check("R6/R9 strobe", strobe_o, m_pend);
            check("R8 done", done_o, m_done);
            check("R3/R4/R9 ser", ser_o, m_busy ? q[0] : 1'b0);
            if (strobe_o && !prev_strobe) check("R6 ser settled before strobe", ser_o, prev_ser);
            if (strobe_o && got_n < 5) begin got_frame[4 - got_n] = ser_o; got_n++; end
            if (done_o) begin
                n_chk++;
                if (got_n != 5 || got_frame !== exp_frame) begin
                    n_fail++;
                    $display("FAIL R3/R4/R5/R8 frame: actual %b (%0d strobes) expected %b", got_frame, got_n, exp_frame);
                end
                got_n = 0;
            end
            if (!rst_n) got_n = 0;
        end
        prev_ser = ser_o; prev_strobe = strobe_o;
    end

    task automatic step; @(negedge clk); #1; endtask

    // Send one word; ticks every gap cycles; optional mid-frame disturbance.
    task automatic send(input logic [3:0] w, input int gap, input bit disturb);
        int k;
        start_i = 1; word_i = w; step();
        start_i = 0;
        k = 0;
        while (!done_o && k < 200) begin
            tick_i = (k % gap) == 0;
            if (disturb && k == 3) begin start_i = 1; word_i = ~w; end // R7, R5
            else if (disturb) begin start_i = 0; word_i = k[3:0]; end
            step(); k++;
        end
        tick_i = 0; start_i = 0;
    endtask

    initial begin
        repeat (3) step();
        check("R1 reset busy", busy_o, 1'b0);
        check("R1 reset strobe", strobe_o, 1'b0);
        check("R1 reset ser", ser_o, 1'b0);
        rst_n = 1; step();
        tick_i = 1; repeat (4) step(); tick_i = 0;          // R9: idle ticks
        check("R9 idle no strobe", strobe_o, 1'b0);
        send(4'b1011, 3, 0);                                  // odd parity
        send(4'b0110, 1, 0);                                  // even, tick every cycle
        send(4'b1001, 2, 1);                                  // R5, R7 disturbance
        // Back-to-back: start raised in the done cycle.
        start_i = 1; word_i = 4'b1110; step(); start_i = 0;
        while (!busy_o) step();
        for (int k = 0; k < 100 && !done_o; k++) begin tick_i = 1; step(); end
        tick_i = 0; start_i = 1; word_i = 4'b0001;          // done cycle is now
        step(); start_i = 0;
        check("R2 start in done cycle", busy_o, 1'b1);
        for (int k = 0; k < 100 && !done_o; k++) begin tick_i = (k % 2) == 0; step(); end
        tick_i = 0; step();
        // Clear in mid-frame.
        start_i = 1; word_i = 4'b1111; step(); start_i = 0;
        tick_i = 1; step(); step(); tick_i = 0;
        rst_n = 0; step(); rst_n = 1;
        check("R1 clear mid-frame", busy_o, 1'b0);
        step();
        for (int w = 0; w < 16; w++) send(4'(w), 1 + (w % 3), 0);
        repeat (3) step();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1500000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule